// File: doc/BRIEF.md
# Multi-Level Prefix Filter Query Front-End

This block sits at the front of an IPv4 route lookup. It accepts one 32-bit destination address at a time and asks four on-chip membership filters, all in the same cycle, whether a subtrie exists for four slice lengths of that address: the top 8, 16, 24 and 32 bits. Each slice is split into a hashed upper part (the key) and a 7-bit lower part that skips the hash through a short delay line and is joined back on. The two short levels use two-probe Bloom bit arrays. The two long levels use fingerprint buckets with a primary and an alternate bucket of four slots each.

Every level that reports a hit yields one candidate word. The candidate words are loaded into a small ordered queue, longest level first, for a downstream bitmap stage. When no level hits, a single default-route entry is queued. The consumer pops entries with a valid/ready handshake. It pulses a flush line once it has found the correct candidate, and that line discards whatever is left.

The address input is valid/ready. `in_ready` is high only when no lookup is in flight and the queue is empty, so one lookup is outstanding at a time. The candidate output is valid/ready: a shown entry stays stable until it is taken or flushed. Filter contents are loaded through a plain write port with no handshake.

Top module: `pfx_probe_top`

## Requirements
- R1: After reset `cand_valid` is 0, `in_ready` is 1 and every filter reports a miss.
- R2: An address is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` then stays low until the queue of that lookup has been fully popped or flushed.
- R3: The first entry of an accepted address is shown on `cand_valid` after the second rising edge that follows the accepting edge.
- R4: Level n (code n-1, n = 1..4) uses slice `addr[31:32-8n]`. Its key is the upper 8n-7 bits of the slice, and its R part is the slice's lowest 7 bits. `cand_addr` = {P address, R part}.
- R5: The hash of a key is a CRC-32 with polynomial 0x04C11DB7 and initial value all ones, no reflection and no final inversion, fed the key bits MSB first. The P address is `crc[PAW-1:0]`.
- R6: Levels 1 and 2 hit when the bits at `crc[IW-1:0]` and at `crc[16+IW-1:16]` of that level's bit array are both set.
- R7: Levels 3 and 4 hit when the fingerprint matches any of the 4 slots of the primary bucket or of the alternate bucket. The fingerprint is `crc[31:32-FPW]` (FPW = 8 for level 3, 16 for level 4), with a zero value replaced by 1. The primary bucket is `crc[BW-1:0]`. The alternate bucket is the primary XOR the low BW bits of the CRC of the fingerprint, taken over FPW bits.
- R8: Hit candidates leave in order of descending level code (3 first, 0 last). There is exactly one entry per hitting level, and each has `cand_dflt` = 0.
- R9: A lookup with no hit produces exactly one entry with `cand_dflt` = 1, `cand_lvl` = 0 and `cand_addr` = 0.
- R10: A `cand_flush` pulse empties the queue by the next cycle. After that `cand_valid` is 0 and `in_ready` is 1.
- R11: While `cand_valid` is 1 and `cand_ready` is 0, the shown entry does not change.
- R12: A write with `wr_lvl` 0/1 stores `wr_val[0]` at bit `wr_idx` of that Bloom array. A write with `wr_lvl` 2/3 stores `wr_val[FPW-1:0]` in slot `wr_slot` of bucket `wr_idx`. Clearing a Bloom bit removes that level's hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Block can take an address |
| in_addr | input | 32 | Destination address |
| wr_en | input | 1 | Filter write strobe |
| wr_lvl | input | 2 | Level code of the written filter |
| wr_idx | input | max(IW,BW) | Bloom bit index or bucket index |
| wr_slot | input | 2 | Bucket slot |
| wr_val | input | max(FP3,FP4) | Bloom bit (bit 0) or fingerprint |
| cand_valid | output | 1 | Queue head valid |
| cand_ready | input | 1 | Consumer pops the head |
| cand_flush | input | 1 | Discard every queued entry |
| cand_dflt | output | 1 | Head is the default-route entry |
| cand_lvl | output | 2 | Level code of the head |
| cand_addr | output | PAW+7 | Combined P/R address of the head |

## Verification
The bench uses the default parameters: 64-bit Bloom arrays, 16 buckets per fingerprint level and a 10-bit P address. With arrays this small, two different keys can share Bloom bits or buckets, so false positives and filled buckets come up across a short run of addresses. The bench therefore keeps its own mirror of the filter contents and works out the expected hits from that mirror, rather than assuming that only inserted keys hit. The alternate-bucket path, the four-deep queue and the default entry are all reached with a handful of inserts.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  // CRC over the low len bits of d, most significant of them first
  function automatic logic [31:0] crc32_bits(input logic [31:0] d, input int len);
    logic [31:0] c;
    logic        fb;
    c = '1;
    for (int i = 31; i >= 0; i--) begin
      if (i < len) begin
        fb = c[31] ^ d[i];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ CRC_POLY;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/pfx_bloom.sv
module pfx_bloom #(
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic          wbit,
  input  logic [31:0]   h,
  output logic          hit
);
  localparam int NBITS = 1 << IW;
  logic [NBITS-1:0] bits;

  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else if (we) bits[widx] <= wbit;
  end

  assign hit = bits[h[IW-1:0]] & bits[h[16 +: IW]];
endmodule

// File: rtl/pfx_cuckoo.sv
module pfx_cuckoo
  import pfx_pkg::*;
#(
  parameter int BW  = 4,
  parameter int FPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [BW-1:0]  wbkt,
  input  logic [1:0]     wslot,
  input  logic [FPW-1:0] wfp,
  input  logic [31:0]    h,
  output logic           hit
);
  localparam int NB = 1 << BW;
  logic [FPW-1:0] slot [NB][4];
  logic [FPW-1:0] fp_raw, fp;
  logic [BW-1:0]  prim, alt;
  logic [31:0]    fh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++)
        for (int s = 0; s < 4; s++) slot[b][s] <= '0;
    end else if (we) begin
      slot[wbkt][wslot] <= wfp;
    end
  end

  always_comb begin
    fp_raw = h[31 -: FPW];
    fp     = (fp_raw == '0) ? FPW'(1) : fp_raw;
    prim   = h[BW-1:0];
    fh     = crc32_bits(32'(fp), FPW);
    alt    = prim ^ fh[BW-1:0];
    hit    = 1'b0;
    for (int s = 0; s < 4; s++)
      if (slot[prim][s] == fp || slot[alt][s] == fp) hit = 1'b1;
  end
endmodule

// File: rtl/pfx_order_fifo.sv
module pfx_order_fifo #(
  parameter int EW = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [3:0]          hit,
  input  logic [3:0][EW-1:0]  cand,
  input  logic                pop,
  input  logic                flush,
  output logic                valid,
  output logic [EW-1:0]       head
);
  logic [EW-1:0] q   [4];
  logic [EW-1:0] nxt [4];
  logic [2:0]    cnt, n;

  // compact hitting levels, longest first; empty set becomes default entry
  always_comb begin
    n = '0;
    for (int i = 0; i < 4; i++) nxt[i] = '0;
    for (int l = 3; l >= 0; l--) begin
      if (hit[l]) begin
        nxt[n[1:0]] = cand[l];
        n = n + 3'd1;
      end
    end
    if (n == 3'd0) begin
      nxt[0] = {1'b1, {(EW-1){1'b0}}};
      n = 3'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < 4; i++) q[i] <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= n;
      for (int i = 0; i < 4; i++) q[i] <= nxt[i];
    end else if (pop && valid) begin
      cnt <= cnt - 3'd1;
      for (int i = 0; i < 3; i++) q[i] <= q[i+1];
    end
  end

  assign valid = (cnt != 3'd0);
  assign head  = q[0];

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !pop && !flush && !load) |=> (valid && $stable(head)));
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !load) |=> !valid);
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && pop && cnt > 3'd1 && !flush && !load)
      |=> (head[EW-2 -: 2] < $past(head[EW-2 -: 2])));
endmodule

// File: rtl/pfx_probe_top.sv
module pfx_probe_top
  import pfx_pkg::*;
#(
  parameter int IW  = 6,
  parameter int BW  = 4,
  parameter int FP3 = 8,
  parameter int FP4 = 16,
  parameter int PAW = 10
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [31:0]                         in_addr,
  input  logic                                wr_en,
  input  logic [1:0]                          wr_lvl,
  input  logic [((IW > BW) ? IW : BW)-1:0]    wr_idx,
  input  logic [1:0]                          wr_slot,
  input  logic [((FP4 > FP3) ? FP4 : FP3)-1:0] wr_val,
  output logic                                cand_valid,
  input  logic                                cand_ready,
  input  logic                                cand_flush,
  output logic                                cand_dflt,
  output logic [1:0]                          cand_lvl,
  output logic [PAW+6:0]                      cand_addr
);
  localparam int RW = 7;
  localparam int AW = PAW + RW;
  localparam int EW = AW + 3;

  logic              accept, s1_v, s2_v;
  logic [31:0]       s1_addr;
  logic [31:0]       h1 [4];
  logic [31:0]       s2_h [4];
  logic [RW-1:0]     r1 [4];
  logic [RW-1:0]     s2_r [4];
  logic [3:0]        hits;
  logic [3:0][EW-1:0] cands;
  logic [EW-1:0]     head;

  assign accept = in_valid && in_ready;

  for (genvar l = 0; l < 4; l++) begin : g_lvl
    localparam int SW = 8 * (l + 1);
    localparam int KW = SW - RW;
    assign h1[l] = crc32_bits(s1_addr >> (32 - KW), KW);
    assign r1[l] = s1_addr[38-SW -: RW];
    assign cands[l] = {1'b0, 2'(l), s2_h[l][PAW-1:0], s2_r[l]};
    if (l < 2) begin : g_bf
      pfx_bloom #(.IW(IW)) u_bf (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_lvl == 2'(l)), .widx(wr_idx[IW-1:0]), .wbit(wr_val[0]),
        .h(s2_h[l]), .hit(hits[l]));
    end else begin : g_cf
      localparam int FPW = (l == 2) ? FP3 : FP4;
      pfx_cuckoo #(.BW(BW), .FPW(FPW)) u_cf (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en && wr_lvl == 2'(l)), .wbkt(wr_idx[BW-1:0]), .wslot(wr_slot),
        .wfp(wr_val[FPW-1:0]), .h(s2_h[l]), .hit(hits[l]));
    end
  end

  // two stages: capture address, then hash; R parts ride along as a delay line
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s1_addr <= '0;
      for (int l = 0; l < 4; l++) begin
        s2_h[l] <= '0;
        s2_r[l] <= '0;
      end
    end else begin
      s1_v <= accept;
      s2_v <= s1_v;
      if (accept) s1_addr <= in_addr;
      for (int l = 0; l < 4; l++) begin
        s2_h[l] <= h1[l];
        s2_r[l] <= r1[l];
      end
    end
  end

  pfx_order_fifo #(.EW(EW)) u_ord (
    .clk(clk), .rst_n(rst_n), .load(s2_v), .hit(hits), .cand(cands),
    .pop(cand_ready), .flush(cand_flush), .valid(cand_valid), .head(head));

  assign in_ready  = !s1_v && !s2_v && !cand_valid;
  assign cand_dflt = head[EW-1];
  assign cand_lvl  = head[EW-2 -: 2];
  assign cand_addr = head[AW-1:0];

  p_one_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && !cand_flush) |=> cand_valid);
  p_dflt_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_dflt) |-> (cand_lvl == 2'd0 && cand_addr == '0));
endmodule

// File: tb/sim_pfx_probe_top.sv
module sim_pfx_probe_top;
  localparam int IW = 6, BW = 4, PAW = 10, AW = PAW + 7, EW = AW + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, cand_ready = 1'b0, cand_flush = 1'b0, wr_en = 1'b0;
  logic [31:0] in_addr = '0;
  logic [1:0]  wr_lvl = '0, wr_slot = '0;
  logic [5:0]  wr_idx = '0;
  logic [15:0] wr_val = '0;
  logic in_ready, cand_valid, cand_dflt;
  logic [1:0] cand_lvl;
  logic [AW-1:0] cand_addr;

  always #2.5 clk = ~clk;

  pfx_probe_top u0 (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic        m_bl [2][64];
  logic [15:0] m_ck [2][16][4];

  // vector: address, then mask of levels to insert before the lookup
  localparam logic [35:0] VEC [8] = '{
    {32'hC0A8_0101, 4'b0000}, {32'hC0A8_0101, 4'b1111}, {32'hC0A8_01FE, 4'b0000},
    {32'h0A14_1E28, 4'b0101}, {32'h0A14_9900, 4'b1000}, {32'h8123_4567, 4'b0011},
    {32'h7F00_0001, 4'b1100}, {32'hC0A8_7777, 4'b0010}};

  function automatic logic [31:0] crc(input logic [31:0] d, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = n - 1; i >= 0; i--) begin
      logic t = c[31] ^ d[i];
      c = c << 1;
      if (t) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

  function automatic logic [31:0] hsh(input int l, input logic [31:0] a);
    int kw = 8 * l + 1;
    return crc(a >> (32 - kw), kw);
  endfunction

  function automatic logic [15:0] fpr(input int l, input logic [31:0] h);
    logic [15:0] f = (l == 2) ? {8'h0, h[31:24]} : h[31:16];
    return (f == 0) ? 16'd1 : f;
  endfunction

  function automatic logic [3:0] altb(input int l, input logic [15:0] f, input logic [3:0] p);
    logic [31:0] c = crc({16'h0, f}, (l == 2) ? 8 : 16);
    return p ^ c[3:0];
  endfunction

  function automatic bit model_hit(input int l, input logic [31:0] a);
    logic [31:0] h = hsh(l, a);
    if (l < 2) return m_bl[l][h[5:0]] && m_bl[l][h[21:16]];
    begin
      logic [15:0] f = fpr(l, h);
      logic [3:0] p = h[3:0], q = altb(l, f, h[3:0]);
      for (int s = 0; s < 4; s++)
        if (m_ck[l-2][p][s] == f || m_ck[l-2][q][s] == f) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int l, input int idx, input int sl, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_lvl = 2'(l); wr_idx = 6'(idx); wr_slot = 2'(sl); wr_val = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic insert(input int l, input logic [31:0] a);  // R12 write port
    logic [31:0] h = hsh(l, a);
    if (l < 2) begin
      m_bl[l][h[5:0]] = 1'b1; wr(l, int'(h[5:0]), 0, 16'd1);
      m_bl[l][h[21:16]] = 1'b1; wr(l, int'(h[21:16]), 0, 16'd1);
    end else begin
      logic [15:0] f = fpr(l, h);
      logic [3:0] bk [2];
      bit put = 1'b0;
      bk[0] = h[3:0]; bk[1] = altb(l, f, h[3:0]);
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 4; s++)
          if (!put && m_ck[l-2][bk[b]][s] == 0) begin
            m_ck[l-2][bk[b]][s] = f; wr(l, int'(bk[b]), s, f); put = 1'b1;
          end
    end
  endtask

  // mode 0: pop all; 1: hold 3 cycles first; 2: pop one then flush
  task automatic lookup(input logic [31:0] a, input int mode);
    logic [EW-1:0] exp [4];
    int n = 0;
    for (int l = 3; l >= 0; l--)
      if (model_hit(l, a)) begin
        logic [31:0] h = hsh(l, a);
        logic [6:0] r = 7'(a >> (24 - 8 * l));
        exp[n] = {1'b0, 2'(l), h[PAW-1:0], r};
        n++;
      end
    if (n == 0) begin exp[0] = {1'b1, {(EW-1){1'b0}}}; n = 1; end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!cand_valid && !in_ready, "R3 R2 busy after accept", {30'h0, cand_valid, in_ready}, 32'h0);
    @(negedge clk);
    chk(!cand_valid, "R3 not yet", {31'h0, cand_valid}, 32'h0);
    @(negedge clk);
    if (mode == 1)
      for (int k = 0; k < 3; k++) begin
        chk(cand_valid && {cand_dflt, cand_lvl, cand_addr} == exp[0], "R11 held entry",
            32'({cand_dflt, cand_lvl, cand_addr}), 32'(exp[0]));
        @(negedge clk);
      end
    for (int i = 0; i < n; i++) begin
      chk(cand_valid && {cand_dflt, cand_lvl, cand_addr} == exp[i],
          "R3 R4 R5 R6 R7 R8 R9 entry", 32'({cand_dflt, cand_lvl, cand_addr}), 32'(exp[i]));
      cand_ready = 1'b1;
      @(negedge clk);
      cand_ready = 1'b0;
      if (mode == 2 && i == 0 && n > 1) begin
        cand_flush = 1'b1;
        @(negedge clk);
        cand_flush = 1'b0;
        chk(!cand_valid && in_ready, "R10 flush", {30'h0, cand_valid, in_ready}, 32'h1);
        break;
      end
    end
    chk(!cand_valid && in_ready, "R2 idle after drain", {30'h0, cand_valid, in_ready}, 32'h1);
  endtask

  initial begin
    for (int l = 0; l < 2; l++) begin
      for (int i = 0; i < 64; i++) m_bl[l][i] = 1'b0;
      for (int b = 0; b < 16; b++) for (int s = 0; s < 4; s++) m_ck[l][b][s] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cand_valid && in_ready, "R1 reset state", {30'h0, cand_valid, in_ready}, 32'h1);
    lookup(32'hDEAD_BEEF, 0);  // R1 empty filters give default
    for (int v = 0; v < 8; v++) begin
      logic [31:0] a = VEC[v][35:4];
      for (int l = 0; l < 4; l++) if (VEC[v][l]) insert(l, a);
      lookup(a, 0);
    end
    lookup(32'hC0A8_0101, 1);  // R11 back-pressure
    lookup(32'hC0A8_0101, 2);  // R10 flush mid-stream
    begin  // R12 clearing a Bloom bit drops the level-2 hit
      logic [31:0] h = hsh(1, 32'hC0A8_0101);
      m_bl[1][h[5:0]] = 1'b0;
      wr(1, int'(h[5:0]), 0, 16'd0);
      chk(!model_hit(1, 32'hC0A8_0101), "R12 model cleared", 32'h0, 32'h0);
      lookup(32'hC0A8_0101, 0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule